// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between the load/store stage of a 32-bit core and a 32-bit single-cycle data memory port. From a base register plus either a second register or a sign-extended 16-bit constant it forms the effective address. It then derives the byte-lane mask, replicates store data across the lanes and drives the memory strobe. On the following cycle it picks the addressed byte or halfword out of the returned word and zero-extends it.

Byte ordering is big-endian: the byte at address offset 0 lives in bits [31:24], and offset 3 lives in bits [7:0]. Access sizes are byte, halfword and word. Every access must be aligned to its size. A misaligned or invalid request is not performed. The block raises an error flag and keeps the memory strobe and lane mask low.

The request side is combinational: address, mask, write data and strobe appear in the same cycle as the request. Load results appear one clock later, marked by a valid pulse. Reset is asserted asynchronously (active low) and released through a two-stage synchronizer. No memory access is issued while reset is still held internally.

Top module: `lsu_be_aligner`

## Requirements
- R1: With `req_imm_form`=0, `mem_addr` equals `base_a + index_b` (modulo 2^32) in the same cycle.
- R2: With `req_imm_form`=1, `mem_addr` equals `base_a` plus `imm16` sign-extended to 32 bits, and `index_b` has no effect.
- R3: Size code 2'b00 (byte) enables exactly one lane: offset k sets `mem_be` bit 3-k. Bit 3 covers data bits [31:24] and bit 0 covers bits [7:0].
- R4: Size code 2'b01 (halfword) at offset 0 gives `mem_be`=4'b1100, and at offset 2 gives 4'b0011.
- R5: Size code 2'b10 (word) at offset 0 gives `mem_be`=4'b1111.
- R6: On an aligned store, `mem_wdata` carries `store_data[7:0]` replicated four times for a byte, `store_data[15:0]` replicated twice for a halfword, and `store_data` unchanged for a word. `mem_we` is 1.
- R7: One cycle after an aligned byte load, `load_data` holds the addressed byte of `mem_rdata` (offset 0 = bits [31:24]) zero-extended to 32 bits.
- R8: One cycle after an aligned halfword load, `load_data` holds the addressed half zero-extended (offset 0 = bits [31:16]). After a word load it holds all of `mem_rdata`.
- R9: A halfword at an odd offset, a word at a nonzero offset, or size code 2'b11 raises `align_err`. In that cycle `mem_strobe`, `mem_we` and `mem_be` stay 0.
- R10: `load_valid` is 1 exactly in the cycle after an aligned load was issued. It stays 0 after stores, errored requests and idle cycles.
- R11: While `rst_n` is low, `load_valid` and `mem_strobe` are 0, even with `req_valid` high. Asserting `rst_n` low clears a pending `load_valid` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_imm_form | input | 1 | 1 = base plus immediate, 0 = base plus register |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| base_a | input | 32 | Base register operand |
| index_b | input | 32 | Index register operand |
| imm16 | input | 16 | Signed immediate offset |
| store_data | input | 32 | Store value, right-justified |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Lane enables, bit 3 = bits [31:24] |
| mem_strobe | output | 1 | Memory access request |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Read word, valid one cycle after strobe |
| align_err | output | 1 | Misaligned or invalid request |
| load_valid | output | 1 | `load_data` valid this cycle |
| load_data | output | 32 | Zero-extended load result |

## Verification
The only state is the pending-load flag and the saved offset and size of that load. If any of these is wrong, it shows on `load_valid` or `load_data` in the single cycle after the load request, as a wrong lane or nonzero upper bits. Lane mask, address and error decoding are combinational, so a fault there shows on `mem_be`, `mem_addr` or `align_err` in the same cycle as the request. Back-to-back loads with different offsets show whether the saved offset belongs to the right request.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] index_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [ADDR_W-1:0] ea
);
  logic [ADDR_W-1:0] imm_sx;
  logic [ADDR_W-1:0] addend;

  always_comb begin
    imm_sx = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    addend = use_imm ? imm_sx : index_b;
    ea     = base_a + addend;
  end
endmodule

// File: rtl/lsu_lane_ctl.sv
module lsu_lane_ctl
  import lsu_align_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFS_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  output logic [LANES-1:0] lane_mask,
  output logic             misalign
);
  // lane k in address order drives mask bit LANES-1-k (big-endian)
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [OFS_W-1:0] K = OFS_W'(k);
    logic sel;
    always_comb begin
      case (size)
        SZ_BYTE: sel = (ofs == K);
        SZ_HALF: sel = (ofs[OFS_W-1:1] == K[OFS_W-1:1]);
        SZ_WORD: sel = 1'b1;
        default: sel = 1'b0;
      endcase
    end
    assign lane_mask[LANES-1-k] = sel;
  end

  always_comb begin
    case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = ofs[0];
      SZ_WORD: misalign = |ofs;
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;

  always_comb begin
    case (size)
      SZ_BYTE: dout = {LANES{din[7:0]}};
      SZ_HALF: dout = {(LANES/2){din[15:0]}};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/lsu_load_pick.sv
module lsu_load_pick
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 2
) (
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;
  localparam int HALVES = LANES / 2;

  always_comb begin
    dout = '0;
    case (size)
      SZ_BYTE: begin
        for (int k = 0; k < LANES; k++) begin
          if (ofs == OFS_W'(k)) dout[7:0] = rdata[DATA_W-1-8*k -: 8];
        end
      end
      SZ_HALF: begin
        for (int h = 0; h < HALVES; h++) begin
          if (ofs[OFS_W-1:1] == (OFS_W-1)'(h)) dout[15:0] = rdata[DATA_W-1-16*h -: 16];
        end
      end
      default: dout = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_be_aligner.sv
module lsu_be_aligner
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_store,
  input  logic                req_imm_form,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   base_a,
  input  logic [ADDR_W-1:0]   index_b,
  input  logic [IMM_W-1:0]    imm16,
  input  logic [DATA_W-1:0]   store_data,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic                mem_strobe,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                align_err,
  output logic                load_valid,
  output logic [DATA_W-1:0]   load_data
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ok = rst_q[1];

  acc_size_e        size_now;
  logic [ADDR_W-1:0] ea;
  logic [LANES-1:0]  mask_raw;
  logic              misalign;
  logic              go;
  logic              ld_issue;

  assign size_now = acc_size_e'(req_size);

  lsu_ea_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_ea (
    .base_a (base_a),
    .index_b(index_b),
    .imm    (imm16),
    .use_imm(req_imm_form),
    .ea     (ea)
  );

  lsu_lane_ctl #(.LANES(LANES), .OFS_W(OFS_W)) u_lane (
    .size     (size_now),
    .ofs      (ea[OFS_W-1:0]),
    .lane_mask(mask_raw),
    .misalign (misalign)
  );

  lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
    .size(size_now),
    .din (store_data),
    .dout(mem_wdata)
  );

  always_comb begin
    go         = req_valid & ~misalign & rst_ok;
    ld_issue   = go & ~req_store;
    mem_addr   = ea;
    mem_strobe = go;
    mem_we     = go & req_store;
    mem_be     = go ? mask_raw : '0;
    align_err  = req_valid & misalign;
  end

  // pending-load state: next-state and register processes
  logic             pend_d, pend_q;
  logic [OFS_W-1:0] ofs_d, ofs_q;
  acc_size_e        sz_d, sz_q;
  logic             cap_en;

  always_comb begin
    pend_d = ld_issue;
    cap_en = ld_issue;
    ofs_d  = ea[OFS_W-1:0];
    sz_d   = size_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ofs_q  <= '0;
      sz_q   <= SZ_BYTE;
    end else begin
      pend_q <= pend_d;
      if (cap_en) begin
        ofs_q <= ofs_d;
        sz_q  <= sz_d;
      end
    end
  end

  lsu_load_pick #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_pick (
    .size (sz_q),
    .ofs  (ofs_q),
    .rdata(mem_rdata),
    .dout (load_data)
  );

  assign load_valid = pend_q;
endmodule

// File: rtl/lsu_be_aligner_chk.sv
module lsu_be_aligner_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_ok,
  input logic                req_valid,
  input logic                req_imm_form,
  input logic [1:0]          req_size,
  input logic [ADDR_W-1:0]   base_a,
  input logic [ADDR_W-1:0]   index_b,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic                mem_strobe,
  input logic                mem_we,
  input logic                align_err,
  input logic                load_valid,
  input logic [DATA_W-1:0]   load_data
);
  assert_ea_reg_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && !req_imm_form) |-> (mem_addr == base_a + index_b));

  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_strobe && req_size == 2'b00) |-> ($countones(mem_be) == 1));

  assert_half_two_lanes_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_strobe && req_size == 2'b01) |-> ($countones(mem_be) == 2));

  assert_word_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_strobe && req_size == 2'b10) |-> (&mem_be));

  assert_byte_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (load_valid && $past(req_size) == 2'b00) |-> (load_data[DATA_W-1:8] == '0));

  assert_err_blocks_access_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    align_err |-> (!mem_strobe && !mem_we && mem_be == '0));

  assert_load_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_strobe && !mem_we) |=> load_valid);

  assert_no_stray_valid_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !(mem_strobe && !mem_we) |=> !load_valid);
endmodule

bind lsu_be_aligner lsu_be_aligner_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_ok),
  .req_valid   (req_valid),
  .req_imm_form(req_imm_form),
  .req_size    (req_size),
  .base_a      (base_a),
  .index_b     (index_b),
  .mem_addr    (mem_addr),
  .mem_be      (mem_be),
  .mem_strobe  (mem_strobe),
  .mem_we      (mem_we),
  .align_err   (align_err),
  .load_valid  (load_valid),
  .load_data   (load_data)
);

// File: tb/lsu_be_aligner_test.sv
module lsu_be_aligner_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_store, req_imm_form;
  logic [1:0]  req_size;
  logic [31:0] base_a, index_b, store_data, mem_rdata;
  logic [15:0] imm16;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic [3:0]  mem_be;
  logic        mem_strobe, mem_we, align_err, load_valid;

  int n_chk = 0;
  int n_fail = 0;

  lsu_be_aligner uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_imm_form(req_imm_form), .req_size(req_size), .base_a(base_a),
    .index_b(index_b), .imm16(imm16), .store_data(store_data),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_strobe(mem_strobe),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .align_err(align_err), .load_valid(load_valid), .load_data(load_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        st;
    logic        im;
    logic [1:0]  sz;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] i;
    logic [31:0] wd;
    logic [31:0] ea;
    logic [3:0]  be;
    logic        er;
    logic [31:0] ld;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,2'd0,32'h1000,32'h3,   16'h0,   32'h0,       32'h1003,    4'b0001,1'b0,32'h000000D4},
    '{1'b0,1'b1,2'd0,32'h2000,32'h0,   16'hFFFE,32'h0,       32'h1FFE,    4'b0010,1'b0,32'h000000C3},
    '{1'b0,1'b0,2'd0,32'h100, 32'h0,   16'h0,   32'h0,       32'h100,     4'b1000,1'b0,32'h000000A1},
    '{1'b0,1'b0,2'd0,32'h101, 32'h0,   16'h0,   32'h0,       32'h101,     4'b0100,1'b0,32'h000000B2},
    '{1'b0,1'b0,2'd1,32'h40,  32'h0,   16'h0,   32'h0,       32'h40,      4'b1100,1'b0,32'h0000A1B2},
    '{1'b0,1'b1,2'd1,32'h40,  32'hDEAD,16'h0002,32'h0,       32'h42,      4'b0011,1'b0,32'h0000C3D4},
    '{1'b0,1'b0,2'd2,32'h10,  32'h20,  16'h0,   32'h0,       32'h30,      4'b1111,1'b0,32'hA1B2C3D4},
    '{1'b1,1'b1,2'd0,32'h8000,32'h0,   16'h8001,32'h1122335A,32'h00000001,4'b0100,1'b0,32'h0},
    '{1'b1,1'b0,2'd1,32'h200, 32'h6,   16'h0,   32'h7777BEEF,32'h206,     4'b0011,1'b0,32'h0},
    '{1'b1,1'b1,2'd2,32'h300, 32'h0,   16'h7FFC,32'h12345678,32'h82FC,    4'b1111,1'b0,32'h0},
    '{1'b0,1'b0,2'd1,32'h41,  32'h0,   16'h0,   32'h0,       32'h41,      4'b0000,1'b1,32'h0},
    '{1'b1,1'b0,2'd2,32'h2,   32'h0,   16'h0,   32'hCAFEF00D,32'h2,       4'b0000,1'b1,32'h0},
    '{1'b0,1'b1,2'd2,32'h100, 32'h0,   16'h0003,32'h0,       32'h103,     4'b0000,1'b1,32'h0},
    '{1'b0,1'b0,2'd3,32'h0,   32'h0,   16'h0,   32'h0,       32'h0,       4'b0000,1'b1,32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_store = 1'b0; req_imm_form = 1'b0; req_size = 2'b00;
    base_a = '0; index_b = '0; imm16 = '0; store_data = '0;
  endtask

  task automatic drive(input vec_t v);
    req_valid = 1'b1; req_store = v.st; req_imm_form = v.im; req_size = v.sz;
    base_a = v.a; index_b = v.b; imm16 = v.i; store_data = v.wd;
  endtask

  function automatic logic [31:0] exp_wdata(input vec_t v);
    case (v.sz)
      2'd0:    return {4{v.wd[7:0]}};
      2'd1:    return {2{v.wd[15:0]}};
      default: return v.wd;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    mem_rdata = 32'hA1B2C3D4;
    rst_n = 1'b0;
    // R11: during reset no strobe even with a valid aligned request
    @(negedge clk);
    drive(VEC[2]);
    #1;
    check("R11 strobe in reset", {31'b0, mem_strobe}, 32'd0);
    check("R11 load_valid in reset", {31'b0, load_valid}, 32'd0);
    @(negedge clk);
    idle();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      vec_t v;
      string ta, tb, tl;
      v = VEC[n];
      ta = v.im ? "R2 addr" : "R1 addr";
      tb = (v.sz == 2'd0) ? "R3 be" : (v.sz == 2'd1) ? "R4 be" : "R5 be";
      tl = (v.sz == 2'd0) ? "R7 load" : "R8 load";
      @(negedge clk);
      drive(v);
      #1;
      check($sformatf("%s v%0d", ta, n), mem_addr, v.ea);
      check($sformatf("R9 err v%0d", n), {31'b0, align_err}, {31'b0, v.er});
      if (v.er) begin
        check($sformatf("R9 blocked v%0d", n), {26'b0, mem_strobe, mem_we, mem_be}, 32'd0);
      end else begin
        check($sformatf("%s v%0d", tb, n), {28'b0, mem_be}, {28'b0, v.be});
        if (v.st) begin
          check($sformatf("R6 wdata v%0d", n), mem_wdata, exp_wdata(v));
          check($sformatf("R6 we v%0d", n), {31'b0, mem_we}, 32'd1);
        end
      end
      @(negedge clk);
      idle();
      #1;
      check($sformatf("R10 valid v%0d", n), {31'b0, load_valid}, {31'b0, !v.st && !v.er});
      if (!v.st && !v.er) check($sformatf("%s v%0d", tl, n), load_data, v.ld);
    end

    // R10 idle cycle: no valid
    @(negedge clk);
    #1;
    check("R10 idle", {31'b0, load_valid}, 32'd0);

    // R7 back-to-back byte loads keep their own offsets
    @(negedge clk);
    drive(VEC[2]);
    @(negedge clk);
    base_a = 32'h103;
    #1;
    check("R7 b2b first", load_data, 32'h000000A1);
    check("R10 b2b first valid", {31'b0, load_valid}, 32'd1);
    @(negedge clk);
    idle();
    mem_rdata = 32'h0F1E2D3C;
    #1;
    check("R7 b2b second", load_data, 32'h0000003C);

    // R11 asynchronous reset clears pending valid
    @(negedge clk);
    drive(VEC[6]);
    @(negedge clk);
    idle();
    #1;
    check("R10 word pending", {31'b0, load_valid}, 32'd1);
    rst_n = 1'b0;
    #1;
    check("R11 async clear", {31'b0, load_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule